// File: doc/BRIEF.md
# Direct Serial Command Port

This block gives software a byte-at-a-time path to a serial flash device alongside the memory-mapped read path. Once software enters the direct mode, each byte it writes to the data register is exchanged full-duplex on a single output line and a single input line. The byte that comes back is held for software to read. Typical uses are erase, program and status-poll commands that the memory-mapped read engine cannot issue.

While the mode is active, the chip select stays asserted across consecutive bytes. This lets a multi-byte command be built from several writes. A memory-mapped read that arrives during direct mode is refused with an error response and raises a sticky error flag. Software clears that flag through a bit-mask clear command. The serial clock is derived from the system clock with a fixed half-period of `HALF` system cycles, and it idles low.

Top module: `dcmd_port`

## Requirements
- R1: After reset the mode is off, `cs_n` is 1, `sck` and `mosi` are 0, `busy` is 0, `rd_mode` is 000 and both status bits are 0.
- R2: An enter request sets the mode and forces `rd_mode` to 000 at the next edge, even when a read-mode write arrives in the same cycle; `cs_n` goes low with the mode.
- R3: An exit request (without enter) clears only the mode bit: `rd_mode` keeps its value, `cs_n` returns high, and any byte in progress is abandoned with `busy` and `sck` low at the next edge.
- R4: A data write in mode while idle starts a transfer; `busy` is 1 for exactly 16*HALF system cycles starting the cycle after the write.
- R5: Bits go out most significant first on `mosi`; `mosi` changes only while `sck` is low, and `miso` is sampled on each rising `sck`.
- R6: When `busy` falls, `rx_data` holds the 8 bits sampled from `miso` (first sampled bit in bit 7) and keeps them until the next transfer completes.
- R7: A data write while `busy` is 1, or while the mode is off, has no effect on the transfer or on `busy`.
- R8: `cs_n` stays low between consecutive bytes for as long as the mode is active.
- R9: While in mode, `mem_req` yields `mem_err`=1 and `mem_fwd`=0 in the same cycle, and status bit 1 becomes 1 at the next edge and stays set; out of mode `mem_fwd` follows `mem_req` and no error is raised.
- R10: `clr_wr` with `clr_mask` bit 1 set clears status bit 1 at the next edge; mask bit 0 does nothing; a new error in the same cycle wins over the clear.
- R11: Status bit 0 always equals `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enter_req | input | 1 | Enter direct mode (one-cycle pulse) |
| exit_req | input | 1 | Leave direct mode (one-cycle pulse) |
| mode_wr | input | 1 | Write strobe for the read-mode field |
| mode_wdata | input | 3 | New read-mode value |
| rd_mode | output | 3 | Current read-mode field (000 = standard read) |
| dmode | output | 1 | Direct mode active |
| tx_wr | input | 1 | Data register write strobe |
| tx_data | input | 8 | Byte to send |
| rx_data | output | 8 | Last received byte |
| busy | output | 1 | Serial transfer in progress |
| mem_req | input | 1 | Memory-mapped read request |
| mem_fwd | output | 1 | Request passed to the read sequencer |
| mem_err | output | 1 | Error response to the request |
| clr_wr | input | 1 | Status clear strobe |
| clr_mask | input | 2 | Status bits to clear |
| status | output | 2 | {access error, busy} |
| sck | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
On every cycle the assertions check the following. Chip select is low whenever a byte is moving. The clock rests low when idle. A transfer starts only from a data write. An enter request zeroes the read mode. An exit keeps the read mode. A refused memory request leaves the error flag set. Bit order, the exact transfer length, the received byte value and the behaviour of writes that should be ignored can only be shown by the bench. The bench does this by sweeping all 256 byte values against a device model that answers with a computed byte, and by placing mode, clear and abort requests at chosen points of a transfer.

// File: rtl/dcmd_port.sv
module dcmd_port #(
  parameter int HALF = 2,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enter_req,
  input  logic          exit_req,
  input  logic          mode_wr,
  input  logic [2:0]    mode_wdata,
  output logic [2:0]    rd_mode,
  output logic          dmode,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_data,
  output logic [DW-1:0] rx_data,
  output logic          busy,
  input  logic          mem_req,
  output logic          mem_fwd,
  output logic          mem_err,
  input  logic          clr_wr,
  input  logic [1:0]    clr_mask,
  output logic [1:0]    status,
  output logic          sck,
  output logic          cs_n,
  output logic          mosi,
  input  logic          miso
);
  localparam int DVW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW  = $clog2(DW) + 1;
  localparam logic [DVW-1:0] DIV_LAST = DVW'(HALF - 1);
  localparam logic [BW-1:0]  BIT_LAST = BW'(DW - 1);

  logic [DVW-1:0] div;
  logic [BW-1:0]  bitn;
  logic [DW-1:0]  sh;
  logic           cap;
  logic           err;

  wire leave = exit_req & ~enter_req;
  wire start = tx_wr & dmode & ~busy & ~leave;
  wire tick  = busy & (div == DIV_LAST);

  assign cs_n    = ~dmode;
  assign mosi    = busy & sh[DW-1];
  assign mem_err = mem_req & dmode;
  assign mem_fwd = mem_req & ~dmode;
  assign status  = {err, busy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dmode   <= 1'b0;
      rd_mode <= 3'b000;
    end else if (enter_req) begin
      dmode   <= 1'b1;
      rd_mode <= 3'b000;
    end else begin
      if (exit_req) dmode <= 1'b0;
      if (mode_wr)  rd_mode <= mode_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sck     <= 1'b0;
      div     <= '0;
      bitn    <= '0;
      sh      <= '0;
      cap     <= 1'b0;
      rx_data <= '0;
    end else if (leave) begin
      busy <= 1'b0;
      sck  <= 1'b0;
      div  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      sck  <= 1'b0;
      div  <= '0;
      bitn <= '0;
      sh   <= tx_data;
    end else if (busy) begin
      if (!tick) begin
        div <= div + 1'b1;
      end else begin
        div <= '0;
        sck <= ~sck;
        if (!sck) begin
          cap <= miso;
        end else begin
          sh   <= {sh[DW-2:0], cap};
          bitn <= bitn + 1'b1;
          if (bitn == BIT_LAST) begin
            busy    <= 1'b0;
            rx_data <= {sh[DW-2:0], cap};
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      err <= 1'b0;
    else if (mem_req && dmode)       err <= 1'b1;
    else if (clr_wr && clr_mask[1])  err <= 1'b0;
  end

  AST_CS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n); // R8
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck); // R5
  AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_wr) && $past(dmode)); // R7
  AST_ENTER_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    enter_req |=> dmode && rd_mode == 3'b000); // R2
  AST_EXIT_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req && !enter_req && !mode_wr |=> !dmode && cs_n && $stable(rd_mode)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && dmode |=> status[1]); // R9
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_fwd && mem_err)); // R9
endmodule

// File: tb/tb_dcmd_port.sv
module tb_dcmd_port;
  localparam int HALF = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enter_req = 0, exit_req = 0, mode_wr = 0, tx_wr = 0, mem_req = 0, clr_wr = 0;
  logic [2:0] mode_wdata = 0;
  logic [7:0] tx_data = 0;
  logic [1:0] clr_mask = 0;
  logic [2:0] rd_mode;
  logic [7:0] rx_data;
  logic [1:0] status;
  logic dmode, busy, mem_fwd, mem_err, sck, cs_n, mosi, miso;
  logic [7:0] slv = 0, mcap = 0;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  dcmd_port #(.HALF(HALF), .DW(8)) dut (.*);

  assign miso = slv[7];
  always @(negedge sck) slv <= {slv[6:0], 1'b0};
  always @(posedge sck) mcap <= {mcap[6:0], mosi};

  function automatic logic [7:0] resp(input logic [7:0] b);
    return 8'(b * 8'd7 + 8'd3) ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic xfer(input logic [7:0] b, input bit inject, input bit full);
    int n = 0;
    slv = resp(b);
    tx_data = b; tx_wr = 1;
    step(); tx_wr = 0;
    while (busy) begin
      chk(status[0] == busy, "R11", status, {1'b0, busy});
      if (cs_n) chk(0, "R8", cs_n, 0);
      if (inject && n == 9) begin tx_data = ~b; tx_wr = 1; end
      else tx_wr = 0;
      n++;
      step();
    end
    tx_wr = 0;
    if (full || inject) chk(n == 16 * HALF, inject ? "R7" : "R4", n, 16 * HALF);
    chk(mcap == b, "R5", mcap, b);
    chk(rx_data == resp(b), "R6", rx_data, resp(b));
    chk(cs_n == 0, "R8", cs_n, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    step(); step();
    chk(!dmode && cs_n && !sck && !mosi && !busy && rd_mode == 0 && status == 0,
        "R1", {dmode, cs_n, sck, mosi, busy, rd_mode, status}, 10'h100);
    rst_n = 1; step();

    mode_wr = 1; mode_wdata = 3'd5; step(); mode_wr = 0;
    chk(rd_mode == 5, "R2", rd_mode, 5);
    mem_req = 1; #1;
    chk(mem_fwd && !mem_err, "R9", {mem_fwd, mem_err}, 2'b10);
    step(); mem_req = 0;
    chk(status[1] == 0, "R9", status, 0);

    tx_data = 8'h3C; tx_wr = 1; step(); tx_wr = 0;
    chk(!busy && !sck, "R7", busy, 0);

    enter_req = 1; mode_wr = 1; mode_wdata = 3'd6; step();
    enter_req = 0; mode_wr = 0;
    chk(dmode && rd_mode == 0 && !cs_n, "R2", {dmode, rd_mode, cs_n}, 5'b10000);

    for (int b = 0; b < 256; b++) begin
      xfer(8'(b), b == 8'h5A, b == 0 || b == 8'hFF);
    end
    repeat (5) step();
    chk(rx_data == resp(8'hFF), "R6", rx_data, resp(8'hFF));

    mem_req = 1; #1;
    chk(mem_err && !mem_fwd, "R9", {mem_fwd, mem_err}, 2'b01);
    step(); mem_req = 0;
    chk(status[1], "R9", status, 2);
    step();
    chk(status[1], "R9", status, 2);
    clr_wr = 1; clr_mask = 2'b01; step();
    chk(status[1], "R10", status, 2);
    clr_mask = 2'b10; step(); clr_wr = 0;
    chk(!status[1], "R10", status, 0);
    clr_wr = 1; mem_req = 1; step(); clr_wr = 0; mem_req = 0;
    chk(status[1], "R10", status, 2);
    clr_wr = 1; clr_mask = 2'b11; step(); clr_wr = 0;
    chk(!status[1], "R10", status, 0);

    mode_wr = 1; mode_wdata = 3'd3; step(); mode_wr = 0;
    exit_req = 1; step(); exit_req = 0;
    chk(!dmode && cs_n && rd_mode == 3, "R3", {dmode, cs_n, rd_mode}, 5'b01011);
    mem_req = 1; #1;
    chk(mem_fwd && !mem_err, "R9", {mem_fwd, mem_err}, 2'b10);
    step(); mem_req = 0;

    enter_req = 1; step(); enter_req = 0;
    chk(rd_mode == 0, "R2", rd_mode, 0);
    slv = 8'h00; tx_data = 8'h81; tx_wr = 1; step(); tx_wr = 0;
    chk(busy, "R4", busy, 1);
    repeat (8) step();
    exit_req = 1; step(); exit_req = 0;
    chk(!busy && !sck && cs_n && !dmode, "R3", {busy, sck, cs_n, dmode}, 4'b0010);
    chk(rx_data == resp(8'hFF), "R6", rx_data, resp(8'hFF));
    repeat (4) step();
    chk(!busy && !sck, "R3", {busy, sck}, 0);

    finish_run();
  end
endmodule